// File: doc/BRIEF.md
# Serial Port Baud Prescaler and Synchronous Clock Generator

This block sets the bit rate of a serial port. A byte-wide register bus loads a 12-bit divisor in two parts: a low byte at address 0 and a high nibble at address 1. Address 1 is shared with a small control register. Bit 7 of the data written to address 1 decides which of the two is updated. A down-counter reloads from the divisor and raises a one-cycle `baud_tick` each time it reaches zero.

When the control register selects synchronous master mode, the block also drives a serial clock output. That clock toggles on every tick. The block also gives two one-cycle strobes: one marks the clock edge on which transmit data should change, and the other marks the edge on which receive data should be sampled. A polarity bit chooses which edge is used for which strobe.

In asynchronous mode the clock output and both strobes stay low, and the polarity bit has no effect. The shift registers, framing and oversampling are left to the logic around this block.

Top module: `serclk_prescaler`

## Requirements
- R1: A write with `wr_addr`=0 stores `wr_data` into divisor bits 7:0, and a read with `rd_addr`=0 returns those bits.
- R2: A write with `wr_addr`=1 and `wr_data[7]`=0 stores `wr_data[3:0]` into divisor bits 11:8. A read with `rd_addr`=1 returns those bits in `rd_data[3:0]`, with `rd_data[7:4]` always zero, even when bits 6:4 were written as ones.
- R3: A write with `wr_addr`=1 and `wr_data[7]`=1 updates the control register and leaves the divisor unchanged. In that byte, bit 6 selects synchronous mode (1) and bit 0 is the polarity.
- R4: After reset the divisor and the control register are zero, `xck`, `tx_change` and `rx_sample` are low, and `baud_tick` is high in every cycle.
- R5: With divisor N held steady, `baud_tick` is high for exactly one cycle out of every N+1. A divisor of 0 gives a tick every cycle.
- R6: A write to the low byte reloads the counter at once with the new 12-bit divisor. If that write occurs in cycle k, the next tick is in cycle k+N+1, and no tick occurs in cycles k+1 to k+N.
- R7: A write of the high nibble alone does not reload the counter. The tick already counting down still occurs on time, and the new value sets the period from the following reload onward.
- R8: In synchronous mode, `xck` changes value in the cycle after each tick and at no other time.
- R9: In synchronous mode with polarity 0, `tx_change` is high for one cycle when `xck` has just risen and `rx_sample` when it has just fallen. With polarity 1 the two strobes are swapped.
- R10: In asynchronous mode, `xck`, `tx_change` and `rx_sample` stay low whatever the polarity bit holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 low divisor byte, 1 shared high/control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 low divisor byte, 1 high divisor nibble |
| rd_data | output | 8 | Read data (combinational) |
| baud_tick | output | 1 | One-cycle prescaler tick |
| xck | output | 1 | Synchronous serial clock |
| tx_change | output | 1 | Strobe for the edge on which transmit data changes |
| rx_sample | output | 1 | Strobe for the edge on which receive data is sampled |

## Verification
Every cycle, the assertions check the counter's step-down and reload, the immediate reload on a low-byte write, and that a control write leaves the divisor unchanged. They also check that `xck` toggles only after a tick, that the strobes are exclusive and match the polarity, and that the outputs are quiet in asynchronous mode. Some behaviours can only be shown by the bench scenarios, because they need a known divisor and a count of cycles between events. These are the exact tick period for each divisor, the position of the first tick after a reload, the delayed effect of a high-nibble-only write, and the value seen on a register readback.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    localparam int BYTE_W = 8;

    // Address map (one address bit on each bus side)
    typedef enum logic {
        REG_DIV_LO = 1'b0,
        REG_DIV_HI = 1'b1
    } reg_addr_e;

    // Field positions in a byte written to the shared address
    localparam int SEL_BIT  = 7;
    localparam int SYNC_BIT = 6;
    localparam int POL_BIT  = 0;

    typedef struct packed {
        logic sync_en;
        logic pol;
    } ctrl_t;

    typedef struct packed {
        logic xck;
        logic tx_change;
        logic rx_sample;
    } edge_out_t;

    function automatic ctrl_t unpack_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.sync_en = b[SYNC_BIT];
        c.pol     = b[POL_BIT];
        return c;
    endfunction

    function automatic logic targets_ctrl(input logic [BYTE_W-1:0] b);
        return b[SEL_BIT];
    endfunction

endpackage

// File: rtl/serclk_regs.sv
module serclk_regs
    import serclk_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DIV_W-1:0]  divisor,
    output ctrl_t             ctrl,
    output logic              reload,
    output logic [DIV_W-1:0]  reload_val
);
    localparam int HI_W = DIV_W - BYTE_W;

    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    ctrl_t             ctrl_q;

    logic wr_lo, wr_hi, wr_ctrl;

    always_comb begin
        wr_lo   = wr_en && (reg_addr_e'(wr_addr) == REG_DIV_LO);
        wr_hi   = wr_en && (reg_addr_e'(wr_addr) == REG_DIV_HI) && !targets_ctrl(wr_data);
        wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == REG_DIV_HI) &&  targets_ctrl(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_lo)   lo_q   <= wr_data;
            if (wr_hi)   hi_q   <= wr_data[HI_W-1:0];
            if (wr_ctrl) ctrl_q <= unpack_ctrl(wr_data);
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_addr_e'(rd_addr) == REG_DIV_LO)
            rd_data = lo_q;
        else
            rd_data[HI_W-1:0] = hi_q;
    end

    assign divisor    = {hi_q, lo_q};
    assign ctrl       = ctrl_q;
    assign reload     = wr_lo;
    assign reload_val = {hi_q, wr_data};

    // R3
    ctrl_keeps_div_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> $stable(divisor));

    // R2
    hi_read_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_e'(rd_addr) == REG_DIV_HI) |-> (rd_data[BYTE_W-1:HI_W] == '0));

    // R1
    lo_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (divisor[BYTE_W-1:0] == $past(wr_data)));
endmodule

// File: rtl/serclk_counter.sv
module serclk_counter #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             reload,
    input  logic [DIV_W-1:0] reload_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q, cnt_d;

    always_comb begin
        tick = (cnt_q == '0);
        if (reload)
            cnt_d = reload_val;
        else if (tick)
            cnt_d = divisor;
        else
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6
    reload_now_chk: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt_q == $past(reload_val)));

    // R7
    natural_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (!reload && cnt_q == '0) |=> (cnt_q == $past(divisor)));
endmodule

// File: rtl/serclk_edgegen.sv
module serclk_edgegen
    import serclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  ctrl_t     ctrl,
    output edge_out_t eo
);
    edge_out_t q;

    always_ff @(posedge clk) begin
        if (rst || !ctrl.sync_en) begin
            q <= '0;
        end else begin
            q.tx_change <= 1'b0;
            q.rx_sample <= 1'b0;
            if (tick) begin
                q.xck <= ~q.xck;
                if (!q.xck) begin
                    q.tx_change <= !ctrl.pol;
                    q.rx_sample <=  ctrl.pol;
                end else begin
                    q.tx_change <=  ctrl.pol;
                    q.rx_sample <= !ctrl.pol;
                end
            end
        end
    end

    assign eo = q;

    // R8
    xck_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sync_en && tick) |=> (q.xck != $past(q.xck)));

    // R8
    xck_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sync_en && !tick) |=> $stable(q.xck));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({q.tx_change, q.rx_sample}));

    // R9
    tx_edge_chk: assert property (@(posedge clk) disable iff (rst)
        q.tx_change |-> (q.xck == !$past(ctrl.pol)) && (q.xck != $past(q.xck)));

    // R9
    rx_edge_chk: assert property (@(posedge clk) disable iff (rst)
        q.rx_sample |-> (q.xck == $past(ctrl.pol)) && (q.xck != $past(q.xck)));

    // R10
    async_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.sync_en |=> (q == '0));
endmodule

// File: rtl/serclk_prescaler.sv
module serclk_prescaler
    import serclk_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    output logic       baud_tick,
    output logic       xck,
    output logic       tx_change,
    output logic       rx_sample
);
    logic [DIV_W-1:0] divisor, reload_val;
    logic             reload, tick;
    ctrl_t            ctrl;
    edge_out_t        eo;

    serclk_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .divisor(divisor), .ctrl(ctrl),
        .reload(reload), .reload_val(reload_val)
    );

    serclk_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk(clk), .rst(rst), .divisor(divisor), .reload(reload),
        .reload_val(reload_val), .tick(tick)
    );

    serclk_edgegen u_edge (
        .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl), .eo(eo)
    );

    assign baud_tick = tick;
    assign xck       = eo.xck;
    assign tx_change = eo.tx_change;
    assign rx_sample = eo.rx_sample;
endmodule

// File: tb/sim_serclk_prescaler.sv
module sim_serclk_prescaler;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       baud_tick, xck, tx_change, rx_sample;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    serclk_prescaler u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .baud_tick(baud_tick),
        .xck(xck), .tx_change(tx_change), .rx_sample(rx_sample)
    );

    localparam int NV = 6;
    localparam logic [11:0] VDIV [NV] = '{12'd0, 12'd1, 12'd2, 12'd5, 12'd17, 12'h103};
    localparam int          VPER [NV] = '{1, 2, 3, 6, 18, 260};

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(input logic [11:0] d);
        bus_wr(1'b1, {4'b0000, d[11:8]});
        bus_wr(1'b0, d[7:0]);
    endtask

    task automatic measure(output int p);
        int guard = 0;
        while (!baud_tick && guard < 5000) begin @(negedge clk); guard++; end
        p = 0;
        do begin @(negedge clk); p++; end while (!baud_tick && p < 5000);
    endtask

    // Watch sync outputs for n cycles, predicting each from the previous sample.
    task automatic watch(input int n, input logic sy, input logic pol, input string req);
        logic px, pt;
        int bx = 0, bs = 0;
        px = xck; pt = baud_tick;
        for (int i = 0; i < n; i++) begin
            logic ex, etx, erx;
            @(negedge clk);
            ex  = sy ? (px ^ pt) : 1'b0;
            etx = sy && pt && (pol ? px : !px);
            erx = sy && pt && (pol ? !px : px);
            if (xck !== ex) bx++;
            if (tx_change !== etx || rx_sample !== erx) bs++;
            px = xck; pt = baud_tick;
        end
        check({req, " xck"}, bx == 0, bx, 0);
        check({req, " strobes"}, bs == 0, bs, 0);
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4 reset state
        rd_addr = 1'b0; #0;
        check("R4 lo", rd_data == 8'h00, rd_data, 0);
        rd_addr = 1'b1; #1;
        check("R4 hi", rd_data == 8'h00, rd_data, 0);
        check("R4 xck/strobes", {xck, tx_change, rx_sample} == 3'b000,
              {xck, tx_change, rx_sample}, 0);
        p = 0;
        for (int i = 0; i < 4; i++) begin
            if (baud_tick) p++;
            @(negedge clk);
        end
        check("R4 tick each cycle", p == 4, p, 4);

        // R5 table of divisors and periods
        for (int v = 0; v < NV; v++) begin
            set_div(VDIV[v]);
            measure(p);
            check("R5 period", p == VPER[v], p, VPER[v]);
        end

        // R1 / R2 / R3 readback
        bus_wr(1'b0, 8'hA5);
        rd_addr = 1'b0; #1;
        check("R1 lo readback", rd_data == 8'hA5, rd_data, 8'hA5);
        bus_wr(1'b1, 8'h7C);
        rd_addr = 1'b1; #1;
        check("R2 hi readback", rd_data == 8'h0C, rd_data, 8'h0C);
        bus_wr(1'b1, 8'hC1);
        rd_addr = 1'b1; #1;
        check("R3 hi unchanged", rd_data == 8'h0C, rd_data, 8'h0C);
        rd_addr = 1'b0; #1;
        check("R3 lo unchanged", rd_data == 8'hA5, rd_data, 8'hA5);
        bus_wr(1'b1, 8'h80);

        // R6 immediate reload on low write (divisor 5)
        bus_wr(1'b1, 8'h00);
        bus_wr(1'b0, 8'd5);
        p = 0;
        for (int i = 0; i <= 5; i++) begin
            if (baud_tick !== (i == 5)) p++;
            if (i < 5) @(negedge clk);
        end
        check("R6 first tick after reload", p == 0, p, 0);

        // R7 high-only write: pending tick on time, then new period
        bus_wr(1'b0, 8'd3);
        bus_wr(1'b1, 8'h01);
        check("R7 no early tick", baud_tick == 1'b0, baud_tick, 0);
        @(negedge clk);
        check("R7 pending tick on time", baud_tick == 1'b1, baud_tick, 1);
        measure(p);
        check("R7 new period", p == 260, p, 260);

        // R8 / R9 sync mode, polarity 0 then 1
        set_div(12'd2);
        bus_wr(1'b1, 8'hC0);
        watch(30, 1'b1, 1'b0, "R8 R9 pol0");
        bus_wr(1'b1, 8'hC1);
        watch(30, 1'b1, 1'b1, "R8 R9 pol1");
        set_div(12'd0);
        watch(10, 1'b1, 1'b1, "R8 R9 div0");

        // R10 async mode with polarity bit set
        set_div(12'd2);
        bus_wr(1'b1, 8'h81);
        watch(30, 1'b0, 1'b1, "R10 async");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule